// File: doc/BRIEF.md
# Key-Locked Flash Command Register Block

This block sits between a 32-bit peripheral bus and an embedded non-volatile memory array. Software sees five word registers: a command word, an array address, a write-data word, a captured read-data word and a lock register. The command word's bits drive the array's control strobes directly, so software sets and clears them one register write at a time to build program, erase and read sequences.

The block starts locked. In that state writes to the command, address and write-data registers have no effect. Writing a fixed 32-bit unlock value to the lock register opens the block. Any other value written there closes it.

An array read works in two steps. Software loads the address, then raises the row, column and sense strobes together. The block latches the array's output word into the read-data register, where the bus can read it.

Top module: `fcmd_gate`

## Requirements
- R1: After reset the block is locked, the lock register reads 0, the address, write-data and read-data registers read 0, and the command word reads the parameter DELAY_RST in bits 5:3 with every other bit 0. All strobe outputs are low.
- R2: A write of KEY_VALUE (default 0x8AAA5551) to offset 0x10 unlocks the block from the next cycle. Reading offset 0x10 then returns 1 in bit 0 and 0 in bits 31:1.
- R3: A write of any other value to offset 0x10, including 0, leaves the block locked from the next cycle, whether it was locked or unlocked before.
- R4: While the block is locked, writes to offsets 0x00 (command), 0x04 (address) and 0x08 (write data) change neither the register read-back nor any output.
- R5: Command bits drive the outputs in this order: bit 0 reg_ctl, bit 1 wr_mode, bit 2 rd_mode, bits 5:3 wait_cfg, bit 6 row_en, bit 7 col_en, bit 8 sense_en, bit 9 info_sel, bit 10 erase_en, bit 11 mass_sel, bit 12 prog_en, bit 13 hv_en. Bits 13:0 read back as written, and bits 31:14 read 0.
- R6: A command write that keeps only bits 5:3 of the previous value clears every strobe and leaves the wait_cfg field unchanged.
- R7: The address register forces bits 1:0 to zero and drives arr_addr. The write-data register drives arr_wdata.
- R8: In every cycle in which row_en, col_en and sense_en are all high, the read-data register (offset 0x0C) takes the arr_rdata value of that cycle at the next clock edge. In any other cycle it holds its value.
- R9: The read-data register cannot be written from the bus. Offsets 0x14 to 0x1C, and any offset whose bits 1:0 are not zero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| arr_addr | output | ADDR_W | Word-aligned array address |
| arr_wdata | output | 32 | Word to program |
| arr_rdata | input | 32 | Word returned by the array |
| reg_ctl | output | 1 | Array under register control |
| wr_mode | output | 1 | Write mode bit |
| rd_mode | output | 1 | Read mode bit |
| wait_cfg | output | 3 | Access delay field |
| row_en | output | 1 | Row strobe |
| col_en | output | 1 | Column strobe |
| sense_en | output | 1 | Sense amplifier enable |
| info_sel | output | 1 | Selects information memory instead of main memory |
| erase_en | output | 1 | Erase strobe |
| mass_sel | output | 1 | Whole-array erase select |
| prog_en | output | 1 | Program strobe |
| hv_en | output | 1 | High-voltage store strobe |

## Verification
The hardest case to reach from the ports is a read capture that must track a changing array word. The capture happens only while all three read strobes are high, and it uses whatever address and memory select are live in that cycle. The stimulus therefore holds the three strobes high while it rewrites the address and toggles info_sel, then drops the strobes and moves the address again. This checks that the captured word follows each change while the strobes are up and freezes once they drop. A second hard case is a lock register that is closed by a value other than 0. That case is reached by unlocking, writing an arbitrary value to the lock register, and then attempting command writes that must leave no trace.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

   localparam int unsigned CMD_W = 14;

   localparam logic [2:0] SLOT_CMD  = 3'd0;
   localparam logic [2:0] SLOT_ADDR = 3'd1;
   localparam logic [2:0] SLOT_WDAT = 3'd2;
   localparam logic [2:0] SLOT_RDAT = 3'd3;
   localparam logic [2:0] SLOT_KEY  = 3'd4;

   typedef struct packed {
      logic       hv;
      logic       prog;
      logic       mass;
      logic       erase;
      logic       info;
      logic       sense;
      logic       col;
      logic       row;
      logic [2:0] delay;
      logic       rd;
      logic       wr;
      logic       ctl;
   } cmd_t;

endpackage

// File: rtl/fcmd_keyguard.sv
module fcmd_keyguard #(
   parameter logic [31:0] KEY_VALUE = 32'h8AAA5551
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_we,
   input  logic [31:0] key_wdata,
   output logic        open_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (key_we) begin
         open_q <= (key_wdata == KEY_VALUE);
      end
   end

endmodule

// File: rtl/fcmd_regs.sv
module fcmd_regs
   import fcmd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DELAY_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_q,
   input  logic              cmd_we,
   input  logic              addr_we,
   input  logic              wdat_we,
   input  logic [31:0]       wdata,
   output cmd_t              cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [31:0]       wdat_q
);

   localparam int unsigned WORD_AW = ADDR_W - 2;

   logic [WORD_AW-1:0] word_q;
   cmd_t               cmd_rst;

   always_comb begin
      cmd_rst       = '0;
      cmd_rst.delay = DELAY_RST[2:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= cmd_rst;
         word_q <= '0;
         wdat_q <= '0;
      end else if (open_q) begin
         if (cmd_we)  cmd_q  <= cmd_t'(wdata[CMD_W-1:0]);
         if (addr_we) word_q <= wdata[ADDR_W-1:2];
         if (wdat_we) wdat_q <= wdata;
      end
   end

   assign addr_q = {word_q, 2'b00};

endmodule

// File: rtl/fcmd_capture.sv
module fcmd_capture (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        row,
   input  logic        col,
   input  logic        sense,
   input  logic [31:0] arr_rdata,
   output logic [31:0] rdat_q
);

   logic fire;
   assign fire = row & col & sense;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (fire) begin
         rdat_q <= arr_rdata;
      end
   end

endmodule

// File: rtl/fcmd_gate.sv
module fcmd_gate
   import fcmd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DELAY_RST = 3,
   parameter logic [31:0] KEY_VALUE = 32'h8AAA5551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [4:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [31:0]       arr_wdata,
   input  logic [31:0]       arr_rdata,
   output logic              reg_ctl,
   output logic              wr_mode,
   output logic              rd_mode,
   output logic [2:0]        wait_cfg,
   output logic              row_en,
   output logic              col_en,
   output logic              sense_en,
   output logic              info_sel,
   output logic              erase_en,
   output logic              mass_sel,
   output logic              prog_en,
   output logic              hv_en
);

   localparam int unsigned PAD_CMD  = 32 - CMD_W;
   localparam int unsigned PAD_ADDR = 32 - ADDR_W;

   if (ADDR_W < 3 || ADDR_W > 31) begin : g_bad_addr_w
      $error("fcmd_gate: ADDR_W must lie in 3..31");
   end
   if (DELAY_RST > 7) begin : g_bad_delay
      $error("fcmd_gate: DELAY_RST must fit in three bits");
   end

   logic              word_ok;
   logic [2:0]        slot;
   logic              key_open;
   cmd_t              cmd_q;
   logic [CMD_W-1:0]  cmd_vec;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       wdat_q;
   logic [31:0]       rdat_q;

   assign word_ok = (bus_addr[1:0] == 2'b00);
   assign slot    = bus_addr[4:2];
   assign cmd_vec = cmd_q;

   fcmd_keyguard #(.KEY_VALUE(KEY_VALUE)) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_we    (bus_we && word_ok && slot == SLOT_KEY),
      .key_wdata (bus_wdata),
      .open_q    (key_open)
   );

   fcmd_regs #(.ADDR_W(ADDR_W), .DELAY_RST(DELAY_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_q  (key_open),
      .cmd_we  (bus_we && word_ok && slot == SLOT_CMD),
      .addr_we (bus_we && word_ok && slot == SLOT_ADDR),
      .wdat_we (bus_we && word_ok && slot == SLOT_WDAT),
      .wdata   (bus_wdata),
      .cmd_q   (cmd_q),
      .addr_q  (addr_q),
      .wdat_q  (wdat_q)
   );

   fcmd_capture u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .row       (cmd_q.row),
      .col       (cmd_q.col),
      .sense     (cmd_q.sense),
      .arr_rdata (arr_rdata),
      .rdat_q    (rdat_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (word_ok) begin
         case (slot)
            SLOT_CMD:  bus_rdata = {{PAD_CMD{1'b0}}, cmd_vec};
            SLOT_ADDR: bus_rdata = {{PAD_ADDR{1'b0}}, addr_q};
            SLOT_WDAT: bus_rdata = wdat_q;
            SLOT_RDAT: bus_rdata = rdat_q;
            SLOT_KEY:  bus_rdata = {31'd0, key_open};
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign arr_addr  = addr_q;
   assign arr_wdata = wdat_q;
   assign reg_ctl   = cmd_q.ctl;
   assign wr_mode   = cmd_q.wr;
   assign rd_mode   = cmd_q.rd;
   assign wait_cfg  = cmd_q.delay;
   assign row_en    = cmd_q.row;
   assign col_en    = cmd_q.col;
   assign sense_en  = cmd_q.sense;
   assign info_sel  = cmd_q.info;
   assign erase_en  = cmd_q.erase;
   assign mass_sel  = cmd_q.mass;
   assign prog_en   = cmd_q.prog;
   assign hv_en     = cmd_q.hv;

endmodule

// File: rtl/fcmd_gate_chk.sv
module fcmd_gate_chk #(
   parameter logic [31:0] KEY_VALUE = 32'h8AAA5551
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_we,
   input logic [4:0]  bus_addr,
   input logic [31:0] bus_wdata,
   input logic        key_open,
   input logic [13:0] cmd_vec,
   input logic [31:0] rdat_q,
   input logic [31:0] arr_rdata
);

   logic key_wr;
   logic trio;
   assign key_wr = bus_we && (bus_addr == 5'h10);
   assign trio   = cmd_vec[6] && cmd_vec[7] && cmd_vec[8];

   a_r2_magic_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && bus_wdata == KEY_VALUE) |=> key_open);

   a_r3_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && bus_wdata != KEY_VALUE) |=> !key_open);

   a_r4_locked_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !key_open |=> $stable(cmd_vec));

   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      trio |=> (rdat_q == $past(arr_rdata)));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !trio |=> $stable(rdat_q));

endmodule

bind fcmd_gate fcmd_gate_chk #(.KEY_VALUE(KEY_VALUE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .key_open  (key_open),
   .cmd_vec   (cmd_vec),
   .rdat_q    (rdat_q),
   .arr_rdata (arr_rdata)
);

// File: tb/test_fcmd_gate.sv
`timescale 1ns/1ps
module test_fcmd_gate;

   localparam int AW = 16;
   localparam logic [31:0] MAGIC = 32'h8AAA5551;
   localparam logic [2:0]  DRST  = 3'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [AW-1:0] arr_addr;
   logic [31:0]   arr_wdata, arr_rdata;
   logic          reg_ctl, wr_mode, rd_mode, row_en, col_en, sense_en;
   logic          info_sel, erase_en, mass_sel, prog_en, hv_en;
   logic [2:0]    wait_cfg;

   int checks = 0;
   int fails  = 0;
   string req = "R1";

   // reference state
   logic          m_open;
   logic [13:0]   m_cmd;
   logic [AW-1:0] m_addr;
   logic [31:0]   m_din, m_dout;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] arr_fn(logic [AW-1:0] a, logic info);
      return info ? ({16'h1F0E, a} ^ 32'h00FF00FF) : {a, ~a};
   endfunction

   assign arr_rdata = arr_fn(arr_addr, info_sel);

   fcmd_gate #(.ADDR_W(AW), .DELAY_RST(DRST), .KEY_VALUE(MAGIC)) i_fcmd_gate (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .reg_ctl(reg_ctl),
      .wr_mode(wr_mode), .rd_mode(rd_mode), .wait_cfg(wait_cfg),
      .row_en(row_en), .col_en(col_en), .sense_en(sense_en),
      .info_sel(info_sel), .erase_en(erase_en), .mass_sel(mass_sel),
      .prog_en(prog_en), .hv_en(hv_en));

   function automatic logic [31:0] model_read(logic [4:0] off);
      if (off[1:0] != 2'b00) return '0;
      case (off[4:2])
         3'd0: return {18'd0, m_cmd};
         3'd1: return {16'd0, m_addr};
         3'd2: return m_din;
         3'd3: return m_dout;
         3'd4: return {31'd0, m_open};
         default: return '0;
      endcase
   endfunction

   task automatic model_step(logic we, logic [4:0] off, logic [31:0] d);
      if (m_cmd[6] && m_cmd[7] && m_cmd[8]) m_dout = arr_fn(m_addr, m_cmd[9]);
      if (we && off[1:0] == 2'b00) begin
         case (off[4:2])
            3'd0: if (m_open) m_cmd = d[13:0];
            3'd1: if (m_open) m_addr = {d[AW-1:2], 2'b00};
            3'd2: if (m_open) m_din = d;
            3'd4: m_open = (d == MAGIC);
            default: ;
         endcase
      end
   endtask

   task automatic check(string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One bus cycle: compare every output against the model, then step.
   task automatic cyc(logic we, logic [4:0] off, logic [31:0] d);
      logic [61:0] act_o, exp_o;
      @(negedge clk);
      bus_we = we; bus_addr = off; bus_wdata = d;
      #1;
      act_o = {hv_en, prog_en, mass_sel, erase_en, info_sel, sense_en, col_en,
               row_en, wait_cfg, rd_mode, wr_mode, reg_ctl, arr_addr, arr_wdata};
      exp_o = {m_cmd, m_addr, m_din};
      check("outputs", {2'b0, act_o}, {2'b0, exp_o});
      check($sformatf("rdata@%h", off), {32'd0, bus_rdata}, {32'd0, model_read(off)});
      @(posedge clk);
      #0.5;
      model_step(we, off, d);
   endtask

   task automatic rd(logic [4:0] off); cyc(1'b0, off, 32'h0); endtask
   task automatic wr(logic [4:0] off, logic [31:0] d); cyc(1'b1, off, d); endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      m_open = 1'b0; m_cmd = {8'd0, DRST, 3'd0}; m_addr = '0; m_din = '0; m_dout = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      req = "R1";
      rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10);
      check("R1 cmd reset", {32'd0, bus_rdata}, 64'h0);  // bus_addr 0x10 -> key reads 0
      // R4 locked writes ignored, R3 wrong key
      req = "R4";
      wr(5'h00, 32'h0000_3FFF); wr(5'h04, 32'h0000_0100); wr(5'h08, 32'hDEAD_BEEF);
      rd(5'h00); rd(5'h04); rd(5'h08);
      req = "R3";
      wr(5'h10, 32'h1234_5678); rd(5'h10);
      wr(5'h00, 32'h0000_0041); rd(5'h00);
      // R2 unlock
      req = "R2";
      wr(5'h10, MAGIC); rd(5'h10);
      // R5 bit map and read-back
      req = "R5";
      wr(5'h00, 32'hFFFF_FFFF); rd(5'h00);
      wr(5'h00, 32'h0000_1555); rd(5'h00);
      wr(5'h00, 32'h0000_2AAA); rd(5'h00);
      // R6 clean-up keeps the delay field
      req = "R6";
      wr(5'h00, 32'h0000_2FE9); rd(5'h00);
      wr(5'h00, 32'h0000_2FE9 & 32'h38); rd(5'h00);
      check("R6 wait_cfg kept", {61'd0, wait_cfg}, 64'd5);
      // R7 address alignment and data out
      req = "R7";
      wr(5'h04, 32'hFFFF_1237); rd(5'h04);
      check("R7 arr_addr", {48'd0, arr_addr}, 64'h1234);
      wr(5'h08, 32'hCAFE_F00D); rd(5'h08);
      // R8 read capture tracking address and memory select
      req = "R8";
      wr(5'h00, 32'h0000_01C1); rd(5'h0C); rd(5'h0C);
      check("R8 main word", {32'd0, bus_rdata}, {32'd0, arr_fn(16'h1234, 1'b0)});
      wr(5'h04, 32'h0000_0A40); rd(5'h0C); rd(5'h0C);
      wr(5'h00, 32'h0000_03C1); rd(5'h0C); rd(5'h0C);
      check("R8 info word", {32'd0, bus_rdata}, {32'd0, arr_fn(16'h0A40, 1'b1)});
      wr(5'h00, 32'h0000_0001); wr(5'h04, 32'h0000_0F00); rd(5'h0C); rd(5'h0C);
      check("R8 hold", {32'd0, bus_rdata}, {32'd0, arr_fn(16'h0A40, 1'b1)});
      // R9 read-only and unused offsets
      req = "R9";
      wr(5'h0C, 32'h1111_2222); rd(5'h0C);
      wr(5'h14, 32'hFFFF_FFFF); rd(5'h14); rd(5'h18); rd(5'h1C);
      wr(5'h01, 32'h0000_3FFF); rd(5'h01); rd(5'h00);
      wr(5'h12, 32'h0000_0000); rd(5'h10);
      // R3 relock by zero and by arbitrary value
      req = "R3";
      wr(5'h10, 32'h0); rd(5'h10);
      wr(5'h00, 32'h0000_1FFF); rd(5'h00);
      wr(5'h10, MAGIC); wr(5'h10, 32'h0000_0055); rd(5'h10);
      req = "R4";
      wr(5'h04, 32'h0000_4444); wr(5'h08, 32'h5); rd(5'h04); rd(5'h08);
      rd(5'h00);

      summary();
      $finish;
   end

endmodule